// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a register-mapped interval timer for use as a system tick or one-shot event source. An up-counter advances on clock-enable pulses from one of three sources, chosen by a coded field. The sources are a bus-side clock enable, a peripheral clock enable, and an oscillator enable. The oscillator enable first passes through a fixed divide-by-eight or through a programmable 4-bit divider. A 12-bit prescaler then divides the selected pulse stream before it reaches the counter.

When a counted pulse arrives while the counter equals the compare register, a sticky match flag is set. In free-run mode the counter keeps counting upward and wraps at its width. In restart mode the counter returns to zero on that pulse, so the match period is compare+1 counted pulses. Software clears the flag by writing one to it. The flag drives the interrupt line only while the interrupt-enable bit is set.

Software uses a single-cycle bus. Writes take effect at the clock edge, and read data is a combinational function of the address. All clock-enable inputs are synchronous to `clk`.

Top module: `cmt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control keeps bit 0 (enable), bit 3 (wait, stored only), bits 8:6 (source code), bit 9 (free-run) and bit 10 (oscillator divider enable), and other bits read zero. Prescaler (offset 0x04) keeps bits 15:0. Interrupt-enable (offset 0x0C) keeps bit 0. Compare (offset 0x10) keeps CNT_W bits, and bits above read zero.
- R3: Source code 1 counts `ipg_tick`, code 2 counts `per_tick`, code 5 counts the oscillator path. Every other code counts nothing.
- R4: Prescaler bits 11:0 hold a value N, and the counter (offset 0x24) increments once per N+1 selected pulses.
- R5: The oscillator path divides `osc_tick` by 8 while control bit 10 is clear. While it is set, the path divides by prescaler bits 15:12 plus one.
- R6: A counted pulse that arrives while the counter equals compare sets status bit 0 (offset 0x08). In free-run mode the counter still increments on that pulse. With bit 9 clear it loads zero instead.
- R7: Writing status with bit 0 set clears the flag, and writing it with bit 0 clear leaves the flag unchanged.
- R8: `irq` is high exactly while the flag and interrupt-enable bit 0 are both set.
- R9: Reads of offsets outside the six registers return zero, and writes to the counter offset do not change the counter.
- R10: While the enable bit is clear, the counter and both divider states stay at zero and pulses are ignored. Counting resumes from zero once the enable bit is set.
- R11: In free-run mode the counter wraps from its maximum value to zero.
- R12: When a compare event and a clearing write to the flag fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ipg_tick | input | 1 | Bus-side clock enable pulse (source code 1) |
| per_tick | input | 1 | Peripheral clock enable pulse (source code 2) |
| osc_tick | input | 1 | Oscillator clock enable pulse (source code 5) |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The compare event sets the flag, and a software write to the status register clears it. Both can land on the same clock edge. The bench first sets the flag with a match and leaves it uncleared. It then moves compare to a later value and steps the counter onto it. On the next edge it drives a counted pulse and the write-one-to-clear in the same cycle. The flag must read one afterwards and the counter must have advanced. A following lone clear must then drop the flag, which shows that the clear path itself works.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int DATA_W = 32;
    localparam int PRE_W  = 12;
    localparam int OSC_W  = 4;

    // register byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_PRE  = 8'h04;
    localparam logic [7:0] OFF_STAT = 8'h08;
    localparam logic [7:0] OFF_IEN  = 8'h0C;
    localparam logic [7:0] OFF_CMP  = 8'h10;
    localparam logic [7:0] OFF_CNT  = 8'h24;

    // control field positions
    localparam int CTL_EN    = 0;
    localparam int CTL_WAIT  = 3;
    localparam int CTL_SRC   = 6;
    localparam int CTL_FREE  = 9;
    localparam int CTL_OSCEN = 10;

    // oscillator divider field position in the prescaler register
    localparam int PRE_OSC_LSB = 12;

    // clock source codes
    localparam logic [2:0] SRC_IPG = 3'd1;
    localparam logic [2:0] SRC_PER = 3'd2;
    localparam logic [2:0] SRC_OSC = 3'd5;

    // fixed oscillator divide-by-8 terminal count
    localparam logic [OSC_W-1:0] OSC_FIXED_LIM = OSC_W'(7);

    typedef struct packed {
        logic       osc_pre_en;
        logic       free_run;
        logic [2:0] src;
        logic       wait_en;
        logic       en;
    } ctl_t;

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]     cnt_val,
    input  logic                 flag,
    output ctl_t                 ctl,
    output logic [15:0]          prer,
    output logic                 ien,
    output logic [CNT_W-1:0]     cmp,
    output logic                 clr_flag
);

    typedef struct packed {
        ctl_t             ctl;
        logic [15:0]      prer;
        logic             ien;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    logic hit_ctrl, hit_pre, hit_stat, hit_ien, hit_cmp, hit_cnt;

    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_pre  = (bus_addr == ADDR_W'(OFF_PRE));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        hit_ien  = (bus_addr == ADDR_W'(OFF_IEN));
        hit_cmp  = (bus_addr == ADDR_W'(OFF_CMP));
        hit_cnt  = (bus_addr == ADDR_W'(OFF_CNT));
    end

    // next-state computation
    always_comb begin
        regs_d   = regs_q;
        clr_flag = 1'b0;
        if (bus_wr) begin
            if (hit_ctrl) begin
                regs_d.ctl.en         = bus_wdata[CTL_EN];
                regs_d.ctl.wait_en    = bus_wdata[CTL_WAIT];
                regs_d.ctl.src        = bus_wdata[CTL_SRC +: 3];
                regs_d.ctl.free_run   = bus_wdata[CTL_FREE];
                regs_d.ctl.osc_pre_en = bus_wdata[CTL_OSCEN];
            end
            if (hit_pre) regs_d.prer = bus_wdata[15:0];
            if (hit_ien) regs_d.ien  = bus_wdata[0];
            if (hit_cmp) regs_d.cmp  = bus_wdata[CNT_W-1:0];
            if (hit_stat) clr_flag   = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CTL_EN]      = regs_q.ctl.en;
            bus_rdata[CTL_WAIT]    = regs_q.ctl.wait_en;
            bus_rdata[CTL_SRC +: 3] = regs_q.ctl.src;
            bus_rdata[CTL_FREE]    = regs_q.ctl.free_run;
            bus_rdata[CTL_OSCEN]   = regs_q.ctl.osc_pre_en;
        end else if (hit_pre) begin
            bus_rdata[15:0] = regs_q.prer;
        end else if (hit_stat) begin
            bus_rdata[0] = flag;
        end else if (hit_ien) begin
            bus_rdata[0] = regs_q.ien;
        end else if (hit_cmp) begin
            bus_rdata[CNT_W-1:0] = regs_q.cmp;
        end else if (hit_cnt) begin
            bus_rdata[CNT_W-1:0] = cnt_val;
        end
    end

    assign ctl  = regs_q.ctl;
    assign prer = regs_q.prer;
    assign ien  = regs_q.ien;
    assign cmp  = regs_q.cmp;

endmodule

// File: rtl/cmt_tick_gen.sv
module cmt_tick_gen
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       src,
    input  logic             osc_pre_en,
    input  logic [PRE_W-1:0] pre_lim,
    input  logic [OSC_W-1:0] osc_lim_prog,
    input  logic             ipg_tick,
    input  logic             per_tick,
    input  logic             osc_tick,
    output logic             cnt_tick
);

    typedef struct packed {
        logic [OSC_W-1:0] osc_cnt;
        logic [PRE_W-1:0] pre_cnt;
    } div_t;

    div_t div_d, div_q;

    logic [OSC_W-1:0] osc_lim;
    logic             osc_run;
    logic             osc_out;
    logic             src_tick;
    logic             pre_out;

    always_comb begin
        div_d    = div_q;
        osc_lim  = osc_pre_en ? osc_lim_prog : OSC_FIXED_LIM;
        osc_run  = en && (src == SRC_OSC);
        osc_out  = osc_run && osc_tick && (div_q.osc_cnt >= osc_lim);

        case (src)
            SRC_IPG: src_tick = ipg_tick;
            SRC_PER: src_tick = per_tick;
            SRC_OSC: src_tick = osc_out;
            default: src_tick = 1'b0;
        endcase

        pre_out = en && src_tick && (div_q.pre_cnt >= pre_lim);

        // oscillator divider
        if (!osc_run)      div_d.osc_cnt = '0;
        else if (osc_tick) div_d.osc_cnt = osc_out ? '0 : div_q.osc_cnt + OSC_W'(1);

        // main prescaler
        if (!en)           div_d.pre_cnt = '0;
        else if (src_tick) div_d.pre_cnt = pre_out ? '0 : div_q.pre_cnt + PRE_W'(1);

        cnt_tick = pre_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_BADSRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_IPG && src != SRC_PER && src != SRC_OSC) |-> !cnt_tick); // R3

    AST_OFF_DIVCLR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (div_q.pre_cnt == '0 && div_q.osc_cnt == '0)); // R10

endmodule

// File: rtl/cmt_count.sv
module cmt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             free_run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } st_t;

    st_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = en && tick && (st_q.cnt == cmp);
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (hit && !free_run) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        // set has priority over the software clear
        if (hit)      st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !(st_q.cnt == cmp && !free_run)) |=> st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(1))); // R4

    AST_EVENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && st_q.cnt == cmp) |=> st_q.flag); // R6

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && st_q.cnt == cmp && !free_run) |=> st_q.cnt == '0); // R6

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(en && tick && st_q.cnt == cmp)) |=> !st_q.flag); // R7

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st_q.cnt == '0); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && en && tick && st_q.cnt == cmp) |=> st_q.flag); // R12

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ipg_tick,
    input  logic              per_tick,
    input  logic              osc_tick,
    output logic              irq
);

    ctl_t             ctl;
    logic [15:0]      prer;
    logic             ien;
    logic [CNT_W-1:0] cmp;
    logic             clr_flag;
    logic [CNT_W-1:0] cnt_val;
    logic             flag;
    logic             cnt_tick;

    cmt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .flag      (flag),
        .ctl       (ctl),
        .prer      (prer),
        .ien       (ien),
        .cmp       (cmp),
        .clr_flag  (clr_flag)
    );

    cmt_tick_gen u_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (ctl.en),
        .src          (ctl.src),
        .osc_pre_en   (ctl.osc_pre_en),
        .pre_lim      (prer[PRE_W-1:0]),
        .osc_lim_prog (prer[PRE_OSC_LSB +: OSC_W]),
        .ipg_tick     (ipg_tick),
        .per_tick     (per_tick),
        .osc_tick     (osc_tick),
        .cnt_tick     (cnt_tick)
    );

    cmt_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl.en),
        .free_run (ctl.free_run),
        .tick     (cnt_tick),
        .cmp      (cmp),
        .clr      (clr_flag),
        .cnt      (cnt_val),
        .flag     (flag)
    );

    assign irq = flag & ien;

    AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CNT) && !cnt_tick && ctl.en) |=> $stable(cnt_val)); // R9

endmodule

// File: tb/cmt_timer_test.sv
`timescale 1ns/1ps
module cmt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ipg_tick = 1'b0;
    logic        per_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

    always #10 clk = ~clk;

    cmt_timer #(.ADDR_W(8), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ipg_tick(ipg_tick),
        .per_tick(per_tick), .osc_tick(osc_tick), .irq(irq)
    );

    function automatic logic [31:0] ctl_word(input bit en, input logic [2:0] src,
                                             input bit frr, input bit oscen);
        return 32'(en) | (32'(src) << 6) | (32'(frr) << 9) | (32'(oscen) << 10);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // kind: 0 ipg, 1 per, 2 osc; drives n consecutive pulse cycles
    task automatic pulse(input int kind, input int n);
        @(negedge clk);
        if (kind == 0) ipg_tick = 1'b1;
        else if (kind == 1) per_tick = 1'b1;
        else osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        ipg_tick = 1'b0; per_tick = 1'b0; osc_tick = 1'b0;
    endtask

    task automatic restart(input logic [31:0] ctl, input logic [31:0] pre);
        wr(A_CTRL, 32'h0);
        wr(A_PRE, pre);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, ctl);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_PRE, v);  check("R1 pre", v, 0);
        rd(A_STAT, v); check("R1 stat", v, 0);
        rd(A_IEN, v);  check("R1 ien", v, 0);
        rd(A_CMP, v);  check("R1 cmp", v, 0);
        rd(A_CNT, v);  check("R1 cnt", v, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R2 ctrl fields", v, 32'h0000_07C9);
        wr(A_PRE, 32'hFFFF_FFFF);
        rd(A_PRE, v); check("R2 pre width", v, 32'h0000_FFFF);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v); check("R2 ien width", v, 32'h1);
        wr(A_CMP, 32'h1234_56AB);
        rd(A_CMP, v); check("R2 cmp width", v, 32'hAB);
        rd(8'h14, v); check("R9 unmapped 0x14", v, 0);
        rd(8'h28, v); check("R9 unmapped 0x28", v, 0);
        wr(A_CNT, 32'h55);
        rd(A_CNT, v); check("R9 counter write ignored", v, 0);
        wr(A_CTRL, 0); wr(A_PRE, 0); wr(A_IEN, 0); wr(A_CMP, 32'hFF);
    endtask

    task automatic t_sources;
        logic [31:0] v;
        restart(ctl_word(1, 3'd1, 1, 0), 0);
        pulse(0, 5); pulse(1, 2);
        rd(A_CNT, v); check("R3 ipg source", v, 5);
        restart(ctl_word(1, 3'd2, 1, 0), 0);
        pulse(0, 4); pulse(1, 3);
        rd(A_CNT, v); check("R3 per source", v, 3);
        restart(ctl_word(1, 3'd3, 1, 0), 0);
        pulse(0, 5); pulse(1, 5); pulse(2, 16);
        rd(A_CNT, v); check("R3 unused code", v, 0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        restart(ctl_word(1, 3'd1, 1, 0), 32'd2);
        pulse(0, 9);
        rd(A_CNT, v); check("R4 divide by 3", v, 3);
        pulse(0, 2);
        rd(A_CNT, v); check("R4 partial", v, 3);
        pulse(0, 1);
        rd(A_CNT, v); check("R4 completes", v, 4);
    endtask

    task automatic t_osc;
        logic [31:0] v;
        restart(ctl_word(1, 3'd5, 1, 0), 32'h0000_3000);
        pulse(2, 16);
        rd(A_CNT, v); check("R5 fixed div8", v, 2);
        restart(ctl_word(1, 3'd5, 1, 1), 32'h0000_3000);
        pulse(2, 8);
        rd(A_CNT, v); check("R5 prog div4", v, 2);
    endtask

    task automatic t_compare;
        logic [31:0] v;
        wr(A_IEN, 0);
        wr(A_CMP, 3);
        restart(ctl_word(1, 3'd1, 1, 0), 0);
        pulse(0, 3);
        rd(A_STAT, v); check("R6 no early flag", v, 0);
        pulse(0, 1);
        rd(A_STAT, v); check("R6 flag set", v, 1);
        rd(A_CNT, v);  check("R6 freerun continues", v, 4);
        check("R8 masked", 32'(irq), 0);
        wr(A_IEN, 1);
        check("R8 enabled", 32'(irq), 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); check("R7 write zero keeps", v, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R7 write one clears", v, 0);
        check("R8 low after clear", 32'(irq), 0);
        wr(A_IEN, 0);
        // restart mode
        wr(A_CMP, 2);
        restart(ctl_word(1, 3'd1, 0, 0), 0);
        pulse(0, 2);
        rd(A_CNT, v); check("R6 restart pre", v, 2);
        pulse(0, 1);
        rd(A_CNT, v);  check("R6 restart reload", v, 0);
        rd(A_STAT, v); check("R6 restart flag", v, 1);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        restart(ctl_word(1, 3'd1, 1, 0), 0);
        pulse(0, 4);
        wr(A_CTRL, 0);
        rd(A_CNT, v); check("R10 cleared", v, 0);
        pulse(0, 3);
        rd(A_CNT, v); check("R10 ignores ticks", v, 0);
        wr(A_CTRL, ctl_word(1, 3'd1, 1, 0));
        pulse(0, 2);
        rd(A_CNT, v); check("R10 resumes from zero", v, 2);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_CMP, 8'd200);
        restart(ctl_word(1, 3'd1, 1, 0), 0);
        pulse(0, 261);
        rd(A_CNT, v); check("R11 wrap", v, 5);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(A_CMP, 2);
        restart(ctl_word(1, 3'd1, 1, 0), 0);
        pulse(0, 3);
        rd(A_STAT, v); check("R12 setup flag", v, 1);
        wr(A_CMP, 5);
        pulse(0, 2);
        rd(A_CNT, v); check("R12 setup count", v, 5);
        @(negedge clk);
        ipg_tick = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
        @(negedge clk);
        ipg_tick = 1'b0; bus_wr = 1'b0;
        rd(A_STAT, v); check("R12 set wins", v, 1);
        rd(A_CNT, v);  check("R12 count advanced", v, 6);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R7 lone clear", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_sources;
        t_prescale;
        t_osc;
        t_compare;
        t_disable;
        t_wrap;
        t_collide;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule